// File: doc/BRIEF.md
# Sliding-Window Decode Sequencer with Traceback Breakpoints

This block sequences a sliding-window trellis decoder through each frame. It fetches the frame configuration, then accumulates state metrics one stage at a time. At each window boundary it starts a traceback, and when the frame is finished it returns to idle. The trellis arithmetic, the metric memories and the transfer engine sit outside the block. They are reached through simple handshakes: an event request for the configuration transfer, a per-stage ready pulse, and a traceback start/done pair.

The host writes a small code into a command register and polls a status field. The block can run a frame straight through. It can also stop in front of any traceback, which gives the host a window to inspect the internal memories. From there the host lets it continue one window at a time or all the way to the end. A stop code clears the whole sequencer at any point.

Top module: `swin_dbg_seq`

## Requirements
- R1: A host write loads `cmd_wdata` into `cmd_q`. Any nonzero code in `cmd_q` is taken on the next clock edge, and that edge sets `cmd_q` back to 0 unless the same edge carries a new write. The reset value of `cmd_q` is 0.
- R2: Code 1 in idle starts a frame. On the taking edge `status` becomes 1 (running) and `cfg_req` pulses high for one cycle. The sequencer then waits for `cfg_valid` and latches the frame length F, the reliability length R and the convergence length C.
- R3: While accumulating, the stage count advances by one on each cycle that `bm_ready` is high. It holds while `bm_ready` is low, so no traceback can begin.
- R4: The window boundaries lie at stage min(D+R+C, F), where D is the number of stages already decided. The first boundary is at min(R+C, F), and each later one is R stages further on, capped at F.
- R5: At a boundary, and when not halted, `tb_start` pulses for one cycle. While the traceback runs, `tb_len` gives the number of stages it decides: R, or F−D for the final window. The sequencer waits for `tb_done`, adds `tb_len` to D and goes on accumulating.
- R6: When the final traceback is done, `done` pulses for one cycle and `status` returns to 0 (idle) on the same edge.
- R7: Code 2 while running arms a halt. Code 2 in idle starts a frame with the halt already armed. With a halt armed, the sequencer stops at the next boundary before it raises `tb_start`, and `status` reads 2 (paused).
- R8: Code 3 while paused runs the pending traceback, keeps the halt armed, and pauses again at the following boundary.
- R9: Code 4 while paused runs the pending traceback, disarms the halt, and completes the frame with no further pauses.
- R10: Code 7 in any state clears every register on the taking edge: `status` 0, `err` 0, `cmd_q` 0, and no pulse outputs.
- R11: A code that does not fit the current state has no effect on the sequence and sets `err`, which stays set until a stop or a reset. The codes that do not fit are: anything other than 1, 2 or 7 in idle; anything other than 2 or 7 while running; anything other than 3, 4 or 7 while paused. `status` never reads 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Host write strobe for the command register |
| cmd_wdata | input | 3 | Command code written by the host |
| cmd_q | output | 3 | Command register contents |
| status | output | 2 | 0 idle, 1 running, 2 paused |
| err | output | 1 | Sticky flag for a command that does not fit the state |
| cfg_req | output | 1 | One-cycle event request for the configuration transfer |
| cfg_valid | input | 1 | Configuration words are present this cycle |
| cfg_frame | input | LW | Frame length F in stages |
| cfg_rel | input | LW | Reliability length R |
| cfg_conv | input | LW | Convergence length C |
| bm_ready | input | 1 | Branch metrics for one stage are ready |
| tb_start | output | 1 | One-cycle traceback start request |
| tb_len | output | LW | Stages the current traceback decides |
| tb_done | input | 1 | Traceback finished |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
On every cycle the assertions check the following:
- the command register empties after a take;
- the configuration request only follows a start code;
- no traceback starts while paused or idle;
- a pause is only entered from running;
- a stop clears the status, error and command;
- the error flag is sticky;
- `done` coincides with the return to idle.

Only the bench scenarios can show the rest. These cover where the boundaries fall for each combination of F, R and C, the `tb_len` value of each window, the stall behaviour without ready pulses, and how many pauses occur under single-step and finish resumes.

// File: rtl/swin_dbg_seq.sv
module swin_dbg_seq #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [2:0]    cmd_wdata,
  output logic [2:0]    cmd_q,
  output logic [1:0]    status,
  output logic          err,
  output logic          cfg_req,
  input  logic          cfg_valid,
  input  logic [LW-1:0] cfg_frame,
  input  logic [LW-1:0] cfg_rel,
  input  logic [LW-1:0] cfg_conv,
  input  logic          bm_ready,
  output logic          tb_start,
  output logic [LW-1:0] tb_len,
  input  logic          tb_done,
  output logic          done
);
  localparam logic [2:0] C_START = 3'd1, C_PAUSE = 3'd2, C_STEP = 3'd3,
                         C_FINISH = 3'd4, C_STOP = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ACC, S_HALT, S_TB} st_t;
  st_t st;

  logic          halt;
  logic [LW-1:0] frame, rel, conv, acc, dec, target;
  logic [LW+1:0] reach;
  logic          last_win, at_edge, stop;
  logic          start_go, start_halt, pause_set, resume, resume_halt, bad;

  assign reach    = {2'b00, dec} + {2'b00, rel} + {2'b00, conv};
  assign target   = (reach >= {2'b00, frame}) ? frame : reach[LW-1:0];
  assign last_win = (target == frame);
  assign at_edge  = (acc == target);
  assign tb_len   = last_win ? frame - dec : rel;
  assign status   = (st == S_IDLE) ? 2'd0 : (st == S_HALT) ? 2'd2 : 2'd1;
  assign stop     = (cmd_q == C_STOP);

  always_comb begin
    start_go = 1'b0; start_halt = 1'b0; pause_set = 1'b0;
    resume = 1'b0; resume_halt = 1'b0; bad = 1'b0;
    if (cmd_q != 3'd0 && !stop) begin
      case (st)
        S_IDLE:
          if (cmd_q == C_START || cmd_q == C_PAUSE) begin
            start_go = 1'b1;
            start_halt = (cmd_q == C_PAUSE);
          end else bad = 1'b1;
        S_HALT:
          if (cmd_q == C_STEP || cmd_q == C_FINISH) begin
            resume = 1'b1;
            resume_halt = (cmd_q == C_STEP);
          end else bad = 1'b1;
        default:
          if (cmd_q == C_PAUSE) pause_set = 1'b1;
          else bad = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd_q <= '0; err <= 1'b0; halt <= 1'b0;
      cfg_req <= 1'b0; tb_start <= 1'b0; done <= 1'b0;
      frame <= '0; rel <= '0; conv <= '0; acc <= '0; dec <= '0;
    end else if (stop) begin
      st <= S_IDLE; cmd_q <= '0; err <= 1'b0; halt <= 1'b0;
      cfg_req <= 1'b0; tb_start <= 1'b0; done <= 1'b0;
      frame <= '0; rel <= '0; conv <= '0; acc <= '0; dec <= '0;
    end else begin
      if (cmd_we)              cmd_q <= cmd_wdata;
      else if (cmd_q != 3'd0)  cmd_q <= '0;
      err      <= err | bad;
      cfg_req  <= 1'b0;
      tb_start <= 1'b0;
      done     <= 1'b0;
      if (pause_set) halt <= 1'b1;
      case (st)
        S_IDLE:
          if (start_go) begin
            st <= S_FETCH; cfg_req <= 1'b1; halt <= start_halt;
            acc <= '0; dec <= '0;
          end
        S_FETCH:
          if (cfg_valid) begin
            frame <= cfg_frame; rel <= cfg_rel; conv <= cfg_conv;
            st <= S_ACC;
          end
        S_ACC:
          if (at_edge) begin
            if (halt) st <= S_HALT;
            else begin st <= S_TB; tb_start <= 1'b1; end
          end else if (bm_ready) acc <= acc + 1'b1;
        S_HALT:
          if (resume) begin
            halt <= resume_halt; st <= S_TB; tb_start <= 1'b1;
          end
        S_TB:
          if (tb_done) begin
            dec <= dec + tb_len;
            if (last_win) begin st <= S_IDLE; done <= 1'b1; end
            else st <= S_ACC;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swin_dbg_seq_chk.sv
module swin_dbg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [2:0] cmd_q,
  input logic [1:0] status,
  input logic       err,
  input logic       cfg_req,
  input logic       tb_start,
  input logic       done
);
  AST_CMD_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != 3'd0 && !cmd_we) |=> (cmd_q == 3'd0)); // R1
  AST_CFG_REQ_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (($past(cmd_q) == 3'd1 || $past(cmd_q) == 3'd2) && status == 2'd1)); // R2
  AST_TB_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    tb_start |-> (status == 2'd1)); // R5
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status == 2'd0 && $past(status) == 2'd1)); // R6
  AST_PAUSE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status == 2'd2) |-> ($past(status) == 2'd1)); // R7
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == 3'd7) |=> (status == 2'd0 && !err && cmd_q == 3'd0 && !tb_start && !cfg_req)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && cmd_q != 3'd7) |=> err); // R11
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'd3); // R11
endmodule

bind swin_dbg_seq swin_dbg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_q(cmd_q), .status(status),
  .err(err), .cfg_req(cfg_req), .tb_start(tb_start), .done(done)
);

// File: tb/tb_swin_dbg_seq.sv
`timescale 1ns/100ps
module tb_swin_dbg_seq;
  localparam int LW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 1'b0, cfg_valid = 1'b0, bm_ready = 1'b0, tb_done = 1'b0;
  logic [2:0] cmd_wdata = '0, cmd_q;
  logic [1:0] status;
  logic err, cfg_req, tb_start, done;
  logic [LW-1:0] cfg_frame = '0, cfg_rel = '0, cfg_conv = '0, tb_len;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  swin_dbg_seq #(.LW(LW)) dut (.*);

  // columns: F, R, C, mode (0 start, 1 step each window, 2 finish after first pause), tracebacks, pauses
  localparam int NV = 6;
  localparam int VEC [NV][6] = '{
    '{20, 4, 6, 0, 4, 0},
    '{20, 4, 6, 1, 4, 4},
    '{20, 4, 6, 2, 4, 1},
    '{ 5, 4, 6, 0, 1, 0},
    '{16, 8, 0, 1, 2, 2},
    '{ 9, 3, 3, 0, 2, 0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] code);
    cmd_we = 1'b1; cmd_wdata = code;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic run_case(input int f, input int r, input int c, input int mode,
                          input int exp_tb, input int exp_pause);
    int dec = 0, ntb = 0, npause = 0, tbw = 0;
    bit sent = 1'b0, seen_done = 1'b0;
    cfg_frame = LW'(f); cfg_rel = LW'(r); cfg_conv = LW'(c);
    put(mode == 0 ? 3'd1 : 3'd2);
    for (int cyc = 0; cyc < 4000 && !seen_done; cyc++) begin
      @(negedge clk);
      cfg_valid = 1'b0; tb_done = 1'b0; cmd_we = 1'b0;
      bm_ready = (cyc % 2 == 1);
      if (cfg_req) cfg_valid = 1'b1;
      if (tb_start) begin
        int reach, tgt, exp_len;
        reach = dec + r + c;
        tgt = (reach >= f) ? f : reach;
        exp_len = (tgt == f) ? f - dec : r;
        chk(tb_len == LW'(exp_len), "R4/R5 tb_len", int'(tb_len), exp_len);
        dec += exp_len; ntb++; tbw = 3;
      end else if (tbw > 0) begin
        tbw--;
        if (tbw == 0) tb_done = 1'b1;
      end
      if (status == 2'd2 && !sent) begin
        npause++; cmd_we = 1'b1; cmd_wdata = (mode == 2) ? 3'd4 : 3'd3; sent = 1'b1;
      end
      if (status != 2'd2) sent = 1'b0;
      if (done) begin
        seen_done = 1'b1;
        chk(status == 2'd0, "R6 idle with done", int'(status), 0);
      end
    end
    bm_ready = 1'b0;
    chk(seen_done, "R6 done seen", int'(seen_done), 1);
    chk(ntb == exp_tb, "R5 traceback count", ntb, exp_tb);
    chk(npause == exp_pause, "R7/R8/R9 pause count", npause, exp_pause);
    chk(dec == f, "R4 decided stages", dec, f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit saw_tb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R11 reset state
    chk(cmd_q == 3'd0, "R1 reset cmd", int'(cmd_q), 0);
    chk(status == 2'd0, "R11 reset status", int'(status), 0);
    chk(!err && !cfg_req && !tb_start && !done, "R10 reset outputs", int'(err), 0);

    // R1 R2 start and consumption
    cfg_frame = 16'd4; cfg_rel = 16'd4; cfg_conv = 16'd0;
    put(3'd1);
    chk(cmd_q == 3'd1, "R1 cmd loaded", int'(cmd_q), 1);
    @(negedge clk);
    chk(cmd_q == 3'd0, "R1 cmd cleared", int'(cmd_q), 0);
    chk(cfg_req == 1'b1, "R2 cfg_req", int'(cfg_req), 1);
    chk(status == 2'd1, "R2 running", int'(status), 1);
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk(cfg_req == 1'b0, "R2 cfg_req one cycle", int'(cfg_req), 0);
    // R3 stall
    saw_tb = 1'b0;
    repeat (20) begin @(negedge clk); if (tb_start) saw_tb = 1'b1; end
    chk(!saw_tb, "R3 stall without ready", int'(saw_tb), 0);
    // R11 unfit command while running
    put(3'd3);
    @(negedge clk);
    chk(err == 1'b1, "R11 err set", int'(err), 1);
    chk(status == 2'd1, "R11 still running", int'(status), 1);
    repeat (4) begin bm_ready = 1'b1; @(negedge clk); end
    bm_ready = 1'b0;
    chk(tb_start == 1'b0, "R3 no early tb", int'(tb_start), 0);
    @(negedge clk);
    chk(tb_start == 1'b1, "R3/R5 tb after 4 stages", int'(tb_start), 1);
    chk(tb_len == 16'd4, "R5 final tb_len", int'(tb_len), 4);
    tb_done = 1'b1;
    @(negedge clk);
    tb_done = 1'b0;
    chk(done == 1'b1 && status == 2'd0, "R6 done and idle", int'(status), 0);
    chk(err == 1'b1, "R11 err sticky", int'(err), 1);

    // R10 stop mid frame
    cfg_frame = 16'd12; cfg_rel = 16'd4; cfg_conv = 16'd4;
    put(3'd1);
    @(negedge clk);
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    put(3'd7);
    @(negedge clk);
    chk(status == 2'd0, "R10 stop idle", int'(status), 0);
    chk(err == 1'b0, "R10 stop clears err", int'(err), 0);
    chk(cmd_q == 3'd0, "R10 stop clears cmd", int'(cmd_q), 0);

    // R7 pause armed while running, halts before traceback
    put(3'd1);
    @(negedge clk);
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    put(3'd2);
    saw_tb = 1'b0;
    bm_ready = 1'b1;
    for (int i = 0; i < 40 && status != 2'd2; i++) begin
      @(negedge clk);
      if (tb_start) saw_tb = 1'b1;
    end
    bm_ready = 1'b0;
    chk(status == 2'd2, "R7 paused", int'(status), 2);
    chk(!saw_tb, "R7 no tb before pause", int'(saw_tb), 0);
    put(3'd7);
    @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++)
      run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule